// File: doc/BRIEF.md
# Timer Core with Software Event Triggers

This block is a small timer core. Software can force any of its events by writing a word to a trigger register. An up-counter is driven by a programmable prescaler and wraps at an auto-reload value. One channel either captures the count on a rising edge of its input (capture mode) or flags a match between the count and a compare value (output mode). A break path removes the primary output enable. A shadow copy of the channel controls (enable, complementary enable, output mode) is moved into the active controls on a commutation event.

Software writes registers through a plain word bus: a strobe, a byte address and 32 data bits. It reads them through a separate combinational read port. Each trigger bit acts once and is never held. Every event sets a sticky status flag. The flag then raises an interrupt or DMA request line when the matching enable is set. Software clears a flag by writing zero to it.

Top module: `tmr_evgen`

## Requirements
- R1: The trigger register sits at word offset 0x08. Bit 0 forces update, bit 1 forces a channel event, bit 5 forces commutation and bit 7 forces break. A write at one clock edge takes effect at the next edge. Each set bit acts exactly once, and a read of 0x08 always returns zero.
- R2: A forced update clears both the counter and the prescaler count, and sets the update flag (status 0x04, bit 0).
- R3: A forced channel event sets the channel flag (status bit 1). irq_ch0 equals that flag AND config (0x00) bit 4. dma_ch0 equals that flag AND config bit 5.
- R4: In capture mode (config bit 1 = 1), a forced channel event or a rising edge of ch_in copies the counter value of that cycle into the value register (0x18). A bus write to 0x18 in the same cycle is overridden.
- R5: A capture that occurs while the channel flag is already set also sets the overcapture flag (status bit 2).
- R6: A forced break or a high brk_in clears the output enable (config bit 3) and sets the break flag (status bit 7). irq_brk equals that flag AND config bit 6, and dma_brk equals that flag AND config bit 7. Break wins over a config write that sets the enable in the same cycle.
- R7: The shadow register at 0x0C holds the enable (bit 0), the complementary enable (bit 1) and the mode (bits 4:2). A forced commutation copies it into the active controls when config bit 2 = 1, and leaves the active controls unchanged when config bit 2 = 0.
- R8: Flags stay set until software writes 0 to their status bit. Writing 1 leaves a flag as it is. A hardware set in the same cycle as a clear wins.
- R9: Writes whose address bits 1:0 are nonzero are ignored, as are writes to the count register (0x1C). Reserved bits of the trigger register have no effect, and reserved bits of every register read as zero.
- R10: While config bit 0 = 1 and cnt_ce = 1, the prescaler counts from 0 to the value at 0x10. The counter advances each time the prescaler wraps. The counter goes from the reload value (0x14) back to 0 and sets the update flag. irq_upd equals the update flag AND config bit 8.
- R11: All trigger bits set in one write act at the same edge. A capture in that write takes the count from before the update clears it.
- R12: In output mode, a counter advance from a count equal to the value register sets the channel flag without changing the value register.
- R13: After reset the count, flags, output enable, active controls and all config bits are zero, and the reload value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Read data |
| cnt_ce | input | 1 | Counter clock enable |
| ch_in | input | 1 | Channel capture input |
| brk_in | input | 1 | Break input, active high |
| cnt_o | output | 16 | Current count |
| flag_upd | output | 1 | Update flag |
| flag_ch0 | output | 1 | Channel flag |
| flag_ovc | output | 1 | Overcapture flag |
| flag_brk | output | 1 | Break flag |
| irq_upd | output | 1 | Update interrupt |
| irq_ch0 | output | 1 | Channel interrupt |
| irq_brk | output | 1 | Break interrupt |
| dma_ch0 | output | 1 | Channel DMA request |
| dma_brk | output | 1 | Break DMA request |
| poe_o | output | 1 | Primary output enable |
| ch_en_o | output | 1 | Active channel enable |
| ch_nen_o | output | 1 | Active complementary enable |
| ocm_o | output | 3 | Active output mode |

## Verification
A wrong trigger pulse or a stuck pulse register shows up at the edge after the write. It appears as a count that did not clear, a flag that did not rise, or an output enable or active control that moved when it should not have. A wrong capture or compare state shows at the read port of 0x18 and on flag_ovc in the cycle after the event. A faulty prescaler shows as a count that drifts from the reference within one reload period. Every output and the read port are compared with a reference model on every cycle, so a bad internal state is reported in the cycle it first reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = IDX_W + 2;

  typedef enum logic [IDX_W-1:0] {
    RG_CFG    = 3'd0,
    RG_STAT   = 3'd1,
    RG_EVGEN  = 3'd2,
    RG_SHADOW = 3'd3,
    RG_PSC    = 3'd4,
    RG_ARL    = 3'd5,
    RG_CCV    = 3'd6,
    RG_CNT    = 3'd7
  } reg_idx_e;

  // trigger bit positions
  localparam int EV_UPD = 0;
  localparam int EV_CH0 = 1;
  localparam int EV_COM = 5;
  localparam int EV_BRK = 7;
  // status bit positions
  localparam int ST_UPD = 0;
  localparam int ST_CH0 = 1;
  localparam int ST_OVC = 2;
  localparam int ST_BRK = 7;
  // config bit positions
  localparam int CF_RUN   = 0;
  localparam int CF_CAP   = 1;
  localparam int CF_CCS   = 2;
  localparam int CF_POE   = 3;
  localparam int CF_CH0IE = 4;
  localparam int CF_CH0DE = 5;
  localparam int CF_BRKIE = 6;
  localparam int CF_BRKDE = 7;
  localparam int CF_UPDIE = 8;

  typedef struct packed {
    logic [2:0] mode;
    logic       nen;
    logic       en;
  } chctl_t;

  typedef struct packed {
    logic upd_ie;
    logic brk_de;
    logic brk_ie;
    logic ch0_de;
    logic ch0_ie;
    logic ccs;
    logic cap;
    logic run;
  } cfg_t;

  typedef struct packed {
    logic brk;
    logic com;
    logic ch0;
    logic upd;
  } ev_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic              cfg_wr,
  output logic              stat_wr,
  output logic              ccv_wr,
  output chctl_t            shadow,
  output logic [PSC_W-1:0]  psc,
  output logic [CNT_W-1:0]  arl,
  output ev_t               ev
);
  logic     wr_ok;
  reg_idx_e idx;
  logic     ev_wr, sh_wr, psc_wr, arl_wr;
  cfg_t     cfg_d;
  chctl_t   shadow_d;
  logic [PSC_W-1:0] psc_d;
  logic [CNT_W-1:0] arl_d;
  ev_t      ev_d;

  always_comb begin
    wr_ok   = wr_en && (wr_addr[1:0] == 2'b00);
    idx     = reg_idx_e'(wr_addr[ADDR_W-1:2]);
    cfg_wr  = wr_ok && (idx == RG_CFG);
    stat_wr = wr_ok && (idx == RG_STAT);
    ev_wr   = wr_ok && (idx == RG_EVGEN);
    sh_wr   = wr_ok && (idx == RG_SHADOW);
    psc_wr  = wr_ok && (idx == RG_PSC);
    arl_wr  = wr_ok && (idx == RG_ARL);
    ccv_wr  = wr_ok && (idx == RG_CCV);

    cfg_d = cfg;
    if (cfg_wr) begin
      cfg_d.run    = wr_data[CF_RUN];
      cfg_d.cap    = wr_data[CF_CAP];
      cfg_d.ccs    = wr_data[CF_CCS];
      cfg_d.ch0_ie = wr_data[CF_CH0IE];
      cfg_d.ch0_de = wr_data[CF_CH0DE];
      cfg_d.brk_ie = wr_data[CF_BRKIE];
      cfg_d.brk_de = wr_data[CF_BRKDE];
      cfg_d.upd_ie = wr_data[CF_UPDIE];
    end
    shadow_d = sh_wr  ? chctl_t'(wr_data[4:0]) : shadow;
    psc_d    = psc_wr ? wr_data[PSC_W-1:0]      : psc;
    arl_d    = arl_wr ? wr_data[CNT_W-1:0]      : arl;

    // trigger bits live for exactly one cycle
    ev_d = '0;
    if (ev_wr) begin
      ev_d.upd = wr_data[EV_UPD];
      ev_d.ch0 = wr_data[EV_CH0];
      ev_d.com = wr_data[EV_COM];
      ev_d.brk = wr_data[EV_BRK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      shadow <= '0;
      psc    <= '0;
      arl    <= '1;
      ev     <= '0;
    end else begin
      cfg    <= cfg_d;
      shadow <= shadow_d;
      psc    <= psc_d;
      arl    <= arl_d;
      ev     <= ev_d;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_ce,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] arl,
  input  logic             ev_upd,
  input  logic             stat_wr,
  input  logic             stat_keep,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             flag_upd
);
  logic [PSC_W-1:0] pscc, pscc_d;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap, upd_set, flag_d, adv;

  always_comb begin
    adv     = run && cnt_ce;
    tick    = adv && (pscc == psc);
    wrap    = tick && (cnt == arl);
    pscc_d  = pscc;
    cnt_d   = cnt;
    upd_set = 1'b0;
    if (ev_upd) begin
      pscc_d  = '0;
      cnt_d   = '0;
      upd_set = 1'b1;
    end else if (adv) begin
      if (tick) begin
        pscc_d  = '0;
        cnt_d   = wrap ? '0 : cnt + 1'b1;
        upd_set = wrap;
      end else begin
        pscc_d = pscc + 1'b1;
      end
    end
    if (upd_set)                  flag_d = 1'b1;
    else if (stat_wr && !stat_keep) flag_d = 1'b0;
    else                          flag_d = flag_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pscc     <= '0;
      cnt      <= '0;
      flag_upd <= 1'b0;
    end else begin
      pscc     <= pscc_d;
      cnt      <= cnt_d;
      flag_upd <= flag_d;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_mode,
  input  logic             ev_ch0,
  input  logic             ch_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ccv_wr,
  input  logic [CNT_W-1:0] ccv_wdata,
  input  logic             stat_wr,
  input  logic             keep_ch0,
  input  logic             keep_ovc,
  output logic [CNT_W-1:0] ccv,
  output logic             flag_ch0,
  output logic             flag_ovc
);
  logic             ch_in_q;
  logic             hw_edge, cap, cmp_hit, ch0_set;
  logic [CNT_W-1:0] ccv_d;
  logic             ch0_d, ovc_d;

  always_comb begin
    hw_edge = cap_mode && ch_in && !ch_in_q;
    cap     = cap_mode && (ev_ch0 || hw_edge);
    cmp_hit = !cap_mode && tick && (cnt == ccv);
    ch0_set = ev_ch0 || hw_edge || cmp_hit;

    if (cap)         ccv_d = cnt;
    else if (ccv_wr) ccv_d = ccv_wdata;
    else             ccv_d = ccv;

    if (ch0_set)                   ch0_d = 1'b1;
    else if (stat_wr && !keep_ch0) ch0_d = 1'b0;
    else                           ch0_d = flag_ch0;

    if (cap && flag_ch0)           ovc_d = 1'b1;
    else if (stat_wr && !keep_ovc) ovc_d = 1'b0;
    else                           ovc_d = flag_ovc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_in_q  <= 1'b0;
      ccv      <= '0;
      flag_ch0 <= 1'b0;
      flag_ovc <= 1'b0;
    end else begin
      ch_in_q  <= ch_in;
      ccv      <= ccv_d;
      flag_ch0 <= ch0_d;
      flag_ovc <= ovc_d;
    end
  end
endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_brk,
  input  logic   brk_in,
  input  logic   ev_com,
  input  logic   ccs,
  input  chctl_t shadow,
  input  logic   cfg_wr,
  input  logic   poe_wdata,
  input  logic   stat_wr,
  input  logic   keep_brk,
  output logic   poe,
  output logic   flag_brk,
  output chctl_t active
);
  logic   brk, poe_d, brk_d;
  chctl_t active_d;

  always_comb begin
    brk = ev_brk || brk_in;
    // break outranks every other source of the enable
    if (brk)         poe_d = 1'b0;
    else if (cfg_wr) poe_d = poe_wdata;
    else             poe_d = poe;

    if (brk)                       brk_d = 1'b1;
    else if (stat_wr && !keep_brk) brk_d = 1'b0;
    else                           brk_d = flag_brk;

    active_d = (ev_com && ccs) ? shadow : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poe      <= 1'b0;
      flag_brk <= 1'b0;
      active   <= '0;
    end else begin
      poe      <= poe_d;
      flag_brk <= brk_d;
      active   <= active_d;
    end
  end
endmodule

// File: rtl/tmr_evgen.sv
module tmr_evgen
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cnt_ce,
  input  logic              ch_in,
  input  logic              brk_in,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_upd,
  output logic              flag_ch0,
  output logic              flag_ovc,
  output logic              flag_brk,
  output logic              irq_upd,
  output logic              irq_ch0,
  output logic              irq_brk,
  output logic              dma_ch0,
  output logic              dma_brk,
  output logic              poe_o,
  output logic              ch_en_o,
  output logic              ch_nen_o,
  output logic [2:0]        ocm_o
);
  logic rst_s1, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  cfg_t             cfg;
  chctl_t           shadow, active;
  logic             cfg_wr, stat_wr, ccv_wr, tick;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] arl, ccv;
  ev_t              ev;
  reg_idx_e         rd_idx;

  tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .cfg_wr(cfg_wr), .stat_wr(stat_wr),
    .ccv_wr(ccv_wr), .shadow(shadow), .psc(psc), .arl(arl), .ev(ev)
  );

  tmr_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .run(cfg.run), .cnt_ce(cnt_ce),
    .psc(psc), .arl(arl), .ev_upd(ev.upd), .stat_wr(stat_wr),
    .stat_keep(wr_data[ST_UPD]), .cnt(cnt_o), .tick(tick), .flag_upd(flag_upd)
  );

  tmr_chan #(.CNT_W(CNT_W)) u_chan (
    .clk(clk), .rst_n(rst_sync_n), .cap_mode(cfg.cap), .ev_ch0(ev.ch0),
    .ch_in(ch_in), .tick(tick), .cnt(cnt_o), .ccv_wr(ccv_wr),
    .ccv_wdata(wr_data[CNT_W-1:0]), .stat_wr(stat_wr),
    .keep_ch0(wr_data[ST_CH0]), .keep_ovc(wr_data[ST_OVC]),
    .ccv(ccv), .flag_ch0(flag_ch0), .flag_ovc(flag_ovc)
  );

  tmr_outctl u_out (
    .clk(clk), .rst_n(rst_sync_n), .ev_brk(ev.brk), .brk_in(brk_in),
    .ev_com(ev.com), .ccs(cfg.ccs), .shadow(shadow), .cfg_wr(cfg_wr),
    .poe_wdata(wr_data[CF_POE]), .stat_wr(stat_wr), .keep_brk(wr_data[ST_BRK]),
    .poe(poe_o), .flag_brk(flag_brk), .active(active)
  );

  always_comb begin
    irq_upd  = flag_upd && cfg.upd_ie;
    irq_ch0  = flag_ch0 && cfg.ch0_ie;
    irq_brk  = flag_brk && cfg.brk_ie;
    dma_ch0  = flag_ch0 && cfg.ch0_de;
    dma_brk  = flag_brk && cfg.brk_de;
    ch_en_o  = active.en;
    ch_nen_o = active.nen;
    ocm_o    = active.mode;
  end

  always_comb begin
    rd_idx  = reg_idx_e'(rd_addr[ADDR_W-1:2]);
    rd_data = '0;
    case (rd_idx)
      RG_CFG: begin
        rd_data[CF_RUN]   = cfg.run;
        rd_data[CF_CAP]   = cfg.cap;
        rd_data[CF_CCS]   = cfg.ccs;
        rd_data[CF_POE]   = poe_o;
        rd_data[CF_CH0IE] = cfg.ch0_ie;
        rd_data[CF_CH0DE] = cfg.ch0_de;
        rd_data[CF_BRKIE] = cfg.brk_ie;
        rd_data[CF_BRKDE] = cfg.brk_de;
        rd_data[CF_UPDIE] = cfg.upd_ie;
      end
      RG_STAT: begin
        rd_data[ST_UPD] = flag_upd;
        rd_data[ST_CH0] = flag_ch0;
        rd_data[ST_OVC] = flag_ovc;
        rd_data[ST_BRK] = flag_brk;
      end
      RG_SHADOW: rd_data[4:0]       = shadow;
      RG_PSC:    rd_data[PSC_W-1:0] = psc;
      RG_ARL:    rd_data[CNT_W-1:0] = arl;
      RG_CCV:    rd_data[CNT_W-1:0] = ccv;
      RG_CNT:    rd_data[CNT_W-1:0] = cnt_o;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_evgen_chk.sv
module tmr_evgen_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input ev_t               ev,
  input cfg_t              cfg,
  input logic              stat_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              brk_in,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              flag_upd,
  input logic              flag_ch0,
  input logic              flag_ovc,
  input logic              flag_brk,
  input logic              poe_o,
  input logic              ch_en_o,
  input logic              ch_nen_o,
  input logic [2:0]        ocm_o
);
  // R1
  evgen_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[ADDR_W-1:2] == RG_EVGEN) |-> (rd_data == '0));

  // R2
  upd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.upd |=> (cnt_o == '0) && flag_upd);

  // R3
  ch0_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.ch0 |=> flag_ch0);

  // R5
  overcap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ch0 && cfg.cap && flag_ch0) |=> flag_ovc);

  // R6
  brk_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.brk || brk_in) |=> (!poe_o && flag_brk));

  // R7
  com_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.com && !cfg.ccs) |=> $stable({ch_en_o, ch_nen_o, ocm_o}));

  // R8
  brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_brk && !(stat_wr && !wr_data[ST_BRK])) |=> flag_brk);
endmodule

bind tmr_evgen tmr_evgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ev(ev), .cfg(cfg), .stat_wr(stat_wr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .brk_in(brk_in),
  .cnt_o(cnt_o), .flag_upd(flag_upd), .flag_ch0(flag_ch0), .flag_ovc(flag_ovc),
  .flag_brk(flag_brk), .poe_o(poe_o), .ch_en_o(ch_en_o), .ch_nen_o(ch_nen_o),
  .ocm_o(ocm_o)
);

// File: tb/tmr_evgen_bench.sv
module tmr_evgen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        b_we;
  logic [4:0]  b_wa, b_ra;
  logic [31:0] b_wd;
  logic        cnt_ce, ch_in, brk_in;
  logic [31:0] rd_data;
  logic [15:0] cnt_o;
  logic flag_upd, flag_ch0, flag_ovc, flag_brk;
  logic irq_upd, irq_ch0, irq_brk, dma_ch0, dma_brk;
  logic poe_o, ch_en_o, ch_nen_o;
  logic [2:0] ocm_o;

  int n_chk = 0;
  int n_err = 0;

  tmr_evgen u_tmr_evgen (
    .clk(clk), .rst_n(rst_n), .wr_en(b_we), .wr_addr(b_wa), .wr_data(b_wd),
    .rd_addr(b_ra), .rd_data(rd_data), .cnt_ce(cnt_ce), .ch_in(ch_in),
    .brk_in(brk_in), .cnt_o(cnt_o), .flag_upd(flag_upd), .flag_ch0(flag_ch0),
    .flag_ovc(flag_ovc), .flag_brk(flag_brk), .irq_upd(irq_upd),
    .irq_ch0(irq_ch0), .irq_brk(irq_brk), .dma_ch0(dma_ch0), .dma_brk(dma_brk),
    .poe_o(poe_o), .ch_en_o(ch_en_o), .ch_nen_o(ch_nen_o), .ocm_o(ocm_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic        m_rs1, m_rs2;
  logic [8:0]  m_cfg;
  logic        m_poe, m_fu, m_fc, m_fo, m_fb, m_chq;
  logic [4:0]  m_sh, m_act;
  logic [15:0] m_psc, m_arl, m_cnt, m_pscc, m_ccv;
  logic [3:0]  m_ev; // {brk, com, ch0, upd}

  task automatic m_reset();
    m_cfg = '0; m_poe = 0; m_fu = 0; m_fc = 0; m_fo = 0; m_fb = 0; m_chq = 0;
    m_sh = '0; m_act = '0; m_psc = '0; m_arl = 16'hFFFF; m_cnt = '0;
    m_pscc = '0; m_ccv = '0; m_ev = '0;
  endtask

  task automatic m_step();
    logic wok, cfgw, stw, evw, shw, pscw, arlw, ccvw;
    logic run, ce_adv, tick, wrap, updset, hw, cap, cmp, chset, brk;
    logic [15:0] cnt_n, pscc_n, ccv_n;
    wok  = b_we && (b_wa[1:0] == 2'b00);
    cfgw = wok && b_wa[4:2] == 3'd0;
    stw  = wok && b_wa[4:2] == 3'd1;
    evw  = wok && b_wa[4:2] == 3'd2;
    shw  = wok && b_wa[4:2] == 3'd3;
    pscw = wok && b_wa[4:2] == 3'd4;
    arlw = wok && b_wa[4:2] == 3'd5;
    ccvw = wok && b_wa[4:2] == 3'd6;
    run = m_cfg[0];
    ce_adv = run && cnt_ce;
    tick = ce_adv && (m_pscc == m_psc);
    wrap = tick && (m_cnt == m_arl);
    cnt_n = m_cnt; pscc_n = m_pscc; updset = 0;
    if (m_ev[0]) begin cnt_n = 0; pscc_n = 0; updset = 1; end
    else if (ce_adv) begin
      if (tick) begin pscc_n = 0; cnt_n = wrap ? 16'd0 : m_cnt + 16'd1; updset = wrap; end
      else pscc_n = m_pscc + 16'd1;
    end
    hw = m_cfg[1] && ch_in && !m_chq;
    cap = m_cfg[1] && (m_ev[1] || hw);
    cmp = !m_cfg[1] && tick && (m_cnt == m_ccv);
    chset = m_ev[1] || hw || cmp;
    ccv_n = cap ? m_cnt : (ccvw ? b_wd[15:0] : m_ccv);
    if (cap && m_fc) m_fo = 1; else if (stw && !b_wd[2]) m_fo = 0;
    if (chset) m_fc = 1; else if (stw && !b_wd[1]) m_fc = 0;
    if (updset) m_fu = 1; else if (stw && !b_wd[0]) m_fu = 0;
    brk = m_ev[3] || brk_in;
    if (brk) m_poe = 0; else if (cfgw) m_poe = b_wd[3];
    if (brk) m_fb = 1; else if (stw && !b_wd[7]) m_fb = 0;
    if (m_ev[2] && m_cfg[2]) m_act = m_sh;
    if (cfgw) m_cfg = b_wd[8:0];
    if (shw) m_sh = b_wd[4:0];
    if (pscw) m_psc = b_wd[15:0];
    if (arlw) m_arl = b_wd[15:0];
    m_ev = evw ? {b_wd[7], b_wd[5], b_wd[1], b_wd[0]} : 4'b0;
    m_chq = ch_in;
    m_cnt = cnt_n; m_pscc = pscc_n; m_ccv = ccv_n;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; m_reset(); end
    else if (!m_rs2) begin m_rs2 = m_rs1; m_rs1 = 1; m_reset(); end
    else m_step();
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    case (a[4:2])
      3'd0: r = {23'b0, m_cfg[8:4], m_poe, m_cfg[2:0]};
      3'd1: r = {24'b0, m_fb, 4'b0, m_fo, m_fc, m_fu};
      3'd3: r = {27'b0, m_sh};
      3'd4: r = {16'b0, m_psc};
      3'd5: r = {16'b0, m_arl};
      3'd6: r = {16'b0, m_ccv};
      3'd7: r = {16'b0, m_cnt};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R10", "count", {16'b0, cnt_o}, {16'b0, m_cnt});
    chk("R2", "flag_upd", {31'b0, flag_upd}, {31'b0, m_fu});
    chk("R3", "flag_ch0", {31'b0, flag_ch0}, {31'b0, m_fc});
    chk("R5", "flag_ovc", {31'b0, flag_ovc}, {31'b0, m_fo});
    chk("R6", "flag_brk", {31'b0, flag_brk}, {31'b0, m_fb});
    chk("R6", "poe", {31'b0, poe_o}, {31'b0, m_poe});
    chk("R7", "active", {27'b0, ocm_o, ch_nen_o, ch_en_o}, {27'b0, m_act});
    chk("R3", "irq/dma", {27'b0, irq_upd, irq_ch0, irq_brk, dma_ch0, dma_brk},
        {27'b0, m_fu && m_cfg[8], m_fc && m_cfg[4], m_fb && m_cfg[6],
         m_fc && m_cfg[5], m_fb && m_cfg[7]});
    chk((b_ra[4:2] == 3'd2) ? "R1" : "R9", "read", rd_data, m_read(b_ra));
  endtask

  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d);
    b_we = we; b_wa = a; b_wd = d;
    @(posedge clk);
    @(negedge clk);
    b_we = 0;
    cmp_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'h0, 32'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] snap;
    void'($urandom(32'd20240611));
    rst_n = 0; b_we = 0; b_wa = 0; b_wd = 0; b_ra = 5'h14;
    cnt_ce = 0; ch_in = 0; brk_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R13 reset state
    chk("R13", "reload reset", rd_data, 32'h0000FFFF);
    chk("R13", "count reset", {16'b0, cnt_o}, 32'h0);
    chk("R13", "poe reset", {31'b0, poe_o}, 32'h0);

    step(1, 5'h10, 32'd2);
    step(1, 5'h14, 32'd5);
    step(1, 5'h0C, 32'h17);
    b_ra = 5'h1C;
    step(1, 5'h00, 32'h1F9); // run, poe, all enables, ccs off
    cnt_ce = 1;
    idle(40); // R10 prescale and wrap

    // R7 commutation gated off, then on
    step(1, 5'h08, 32'h20); idle(1);
    chk("R7", "gated commutation", {27'b0, ocm_o, ch_nen_o, ch_en_o}, 32'h0);
    step(1, 5'h00, 32'h1FD);
    step(1, 5'h08, 32'h20); idle(1);
    chk("R7", "commutation load", {27'b0, ocm_o, ch_nen_o, ch_en_o}, 32'h17);

    // R2 forced update
    idle(3);
    step(1, 5'h08, 32'h1); idle(1);
    chk("R2", "count cleared", {16'b0, cnt_o}, 32'h0);
    chk("R2", "update flag", {31'b0, flag_upd}, 32'h1);

    // R8 write-1 keeps, write-0 clears
    cnt_ce = 0;
    step(1, 5'h04, 32'hFFFFFFFF);
    chk("R8", "write one keeps", {31'b0, flag_upd}, 32'h1);
    step(1, 5'h04, 32'h0);
    chk("R8", "write zero clears", {31'b0, flag_upd}, 32'h0);

    // R6 break outranks a same-cycle enable write
    step(1, 5'h08, 32'h80);
    step(1, 5'h00, 32'h1FD);
    chk("R6", "break wins", {31'b0, poe_o}, 32'h0);
    chk("R6", "break irq", {30'b0, irq_brk, dma_brk}, 32'h3);
    step(1, 5'h00, 32'h1FD);
    chk("R6", "poe restored", {31'b0, poe_o}, 32'h1);
    brk_in = 1; idle(1); brk_in = 0;
    chk("R6", "brk_in kill", {31'b0, poe_o}, 32'h0);

    // R4 / R5 forced capture and overcapture
    step(1, 5'h00, 32'h1FF);
    step(1, 5'h04, 32'h0);
    cnt_ce = 1; idle(5);
    step(1, 5'h08, 32'h2);
    snap = cnt_o;
    b_ra = 5'h18;
    idle(1);
    chk("R4", "captured value", rd_data, {16'b0, snap});
    step(1, 5'h08, 32'h2); idle(1);
    chk("R5", "overcapture", {31'b0, flag_ovc}, 32'h1);

    // R11 combined triggers in one write
    step(1, 5'h00, 32'h1FF);
    step(1, 5'h04, 32'h0);
    idle(4);
    step(1, 5'h08, 32'hA3);
    snap = cnt_o;
    idle(1);
    chk("R11", "capture before clear", rd_data, {16'b0, snap});
    chk("R11", "all acted", {27'b0, flag_upd, flag_ch0, flag_brk, poe_o, ch_en_o},
        {27'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});

    // R9 unaligned, read-only and reserved trigger bits
    b_ra = 5'h00;
    step(1, 5'h01, 32'h0);
    chk("R9", "unaligned ignored", rd_data, m_read(5'h00));
    step(1, 5'h1C, 32'h1234);
    step(1, 5'h04, 32'h0);
    step(1, 5'h08, 32'h5C); idle(1);
    chk("R9", "reserved triggers", {28'b0, flag_upd, flag_ch0, flag_ovc, flag_brk}, 32'h0);

    // R12 compare in output mode
    step(1, 5'h10, 32'd0);
    step(1, 5'h18, 32'd3);
    step(1, 5'h00, 32'h1FD);
    step(1, 5'h08, 32'h1);
    step(1, 5'h04, 32'h0);
    idle(6);
    chk("R12", "compare flag", {31'b0, flag_ch0}, 32'h1);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, d;
      logic [4:0]  a;
      r = $urandom;
      cnt_ce = (r[1:0] != 2'b00);
      ch_in  = r[2];
      brk_in = (r[9:4] == 6'd0);
      b_ra   = {r[12:10], 2'b00};
      d = $urandom;
      a = {r[15:13], (r[20:16] == 5'd0) ? 2'b10 : 2'b00};
      case (r[15:13])
        3'd4: d = {30'b0, d[1:0]};
        3'd5: d = {28'b0, d[3:0]};
        3'd6: d = {28'b0, d[3:0]};
        3'd1: d = d | ((r[21]) ? 32'hFFFFFF00 : 32'h0);
        default: ;
      endcase
      step(r[24:22] < 3'd3, a, d);
    end
    finish_run();
  end
endmodule